// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block pulls outbound packets for one serial channel out of a ring of 8-byte transmit descriptors kept in host memory. A descriptor names one buffer segment. A packet is a chain of one or more descriptors that ends at a descriptor marked as last. Each scan request starts a pass. In one pass the block serves packets one after another. For each packet it first checks the whole chain for ownership and adds up the segment lengths. It then fetches the buffer words, streams the kept bytes one per cycle with a last flag, hands the descriptors back to the host and raises a completion pulse.

The state machine uses these states:
- `ST_IDLE`: waiting for a pass.
- `ST_START`: line-ready gate before each packet.
- `ST_SCAN`: ownership and length walk over the chain.
- `ST_DESC0` and `ST_DESC1`: read a descriptor's flag word and address word.
- `ST_FETCH`: read one buffer word.
- `ST_EMIT`: emit one byte lane per cycle.
- `ST_RELEASE`: clear a non-first descriptor.
- `ST_HEADCLR`: clear the head descriptor and pulse done.

The transitions are:
- IDLE→START on a scan request.
- START→SCAN when the line is ready, START→IDLE when it is not.
- SCAN→SCAN on an owned non-last descriptor, SCAN→DESC0 on an owned last descriptor, SCAN→IDLE on a non-owned descriptor.
- DESC0→DESC1.
- DESC1→FETCH, or DESC1→RELEASE for a zero-length segment.
- FETCH→EMIT.
- EMIT→FETCH at a word boundary, EMIT→RELEASE at the end of a segment.
- RELEASE→DESC0, or RELEASE→HEADCLR after the last descriptor.
- HEADCLR→START for the next packet, or HEADCLR→IDLE once the pass limit is reached.

Top module: `txr_ring_reader`

## Requirements
- R1: A descriptor is two 32-bit words at a ring address. In word 0, bit 31 means owned by the block, bit 30 means first segment, bit 29 means last segment, and bits [15:0] hold the length field. Word 1 is a word-aligned buffer address.
- R2: With `mode_i` = 0, the segment length in bytes equals the length field.
- R3: With `mode_i` = 1, the segment length is the length field times four. When bit 20 is set, the value in bits [25:23+1] (that is, [25:24]) is subtracted from it.
- R4: The pad value is bits [23:22] of the final descriptor. The packet keeps the sum of its segment lengths minus ((4 − pad) mod 4), with a floor of zero. `byte_last_o` marks the final kept byte, and no byte follows it before `tx_done_o`.
- R5: Bytes of each buffer word leave lowest lane first, bits [7:0] before [15:8]. Segments are joined in chain order. A zero-length segment adds nothing.
- R6: If a descriptor in the chain is not owned, the packet is dropped. No byte is emitted, no memory write is made, the pass ends, and the current pointer stays on the head descriptor.
- R7: After its data, each descriptor whose first-segment bit is clear gets word 0 written to zero. The head descriptor's word 0 is written to zero last. `tx_done_o` pulses for one cycle with that write.
- R8: Ring advance depends on the mode. In mode 0 the pointer adds 8 and wraps to ring start when the result equals ring end. In mode 1 the pointer wraps to ring start when it already equals ring end, and otherwise adds 8.
- R9: A pulse on `scan_req_i` starts a pass of at most 16 packets. The pass ends early when the head descriptor is not owned, or when `line_ready_i` is low as a packet is about to start. `busy_o` is high for the whole pass.
- R10: A memory request holds its address and direction stable until `mem_ack_i`.
- R11: After reset, no request is made, no byte is emitted and `busy_o` is low. `ring_init_i` pulsed while idle loads the current pointer from `ring_start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Length and wrap variant, held stable during a pass |
| ring_start_i | input | 32 | First descriptor address of the ring |
| ring_end_i | input | 32 | Ring end address used by the wrap rule |
| ring_init_i | input | 1 | Load current pointer from ring start while idle |
| scan_req_i | input | 1 | Start a scan pass |
| line_ready_i | input | 1 | Line side can accept a packet |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access done; read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| byte_valid_o | output | 1 | A packet byte is present |
| byte_data_o | output | 8 | Packet byte |
| byte_last_o | output | 1 | Final kept byte of the packet |
| tx_done_o | output | 1 | One-cycle packet completion pulse |
| busy_o | output | 1 | Scan pass in progress |

## Verification
The assertions check four things on every cycle:
- The request/acknowledge hold rule.
- The one-cycle shape of the done pulse.
- That no byte appears between a last-flagged byte and the done pulse.
- That no pass exceeds the packet limit, and that mode 0 never leaves the pointer on ring end.

Only the bench scenarios can show the rest: the kept byte count for each length, subtract and pad combination; byte order across lanes and segments; the release write order; the different wrap points of the two modes; and that an aborted chain leaves both memory and the pointer untouched.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int OWN_BIT    = 31;
    localparam int FS_BIT     = 30;
    localparam int LS_BIT     = 29;
    localparam int SUB_LO     = 24;
    localparam int PAD_LO     = 22;
    localparam int SUB_EN_BIT = 20;
    localparam int DESC_BYTES = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_SCAN,
        ST_DESC0,
        ST_DESC1,
        ST_FETCH,
        ST_EMIT,
        ST_RELEASE,
        ST_HEADCLR
    } txr_state_e;

endpackage

// File: rtl/txr_seglen.sv
module txr_seglen #(
    parameter int LEN_W = 16
) (
    input  logic             mode_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             sub_en_i,
    input  logic [1:0]       sub_i,
    output logic [LEN_W+1:0] seg_len_o
);
    localparam int SEG_W = LEN_W + 2;

    logic [SEG_W-1:0] words_len;
    logic [SEG_W-1:0] sub_amt;

    always_comb begin
        words_len = {len_i, 2'b00};
        sub_amt   = sub_en_i ? SEG_W'(sub_i) : '0;
        if (mode_i) begin
            seg_len_o = words_len - sub_amt;
        end else begin
            seg_len_o = {2'b00, len_i};
        end
    end
endmodule

// File: rtl/txr_ring_step.sv
module txr_ring_step #(
    parameter int AW   = 32,
    parameter int STEP = 8
) (
    input  logic          mode_i,
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] end_i,
    output logic [AW-1:0] next_o
);
    logic [AW-1:0] inc;

    always_comb begin
        inc = ptr_i + AW'(STEP);
        if (mode_i) begin
            next_o = (ptr_i == end_i) ? start_i : inc;
        end else begin
            next_o = (inc == end_i) ? start_i : inc;
        end
    end
endmodule

// File: rtl/txr_ring_reader.sv
module txr_ring_reader
    import txr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MAX_PKTS = 16,
    parameter int LEN_W    = 16,
    parameter int TOT_W    = 24
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          mode_i,
    input  logic [AW-1:0] ring_start_i,
    input  logic [AW-1:0] ring_end_i,
    input  logic          ring_init_i,
    input  logic          scan_req_i,
    input  logic          line_ready_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [31:0]   mem_rdata_i,
    output logic          byte_valid_o,
    output logic [7:0]    byte_data_o,
    output logic          byte_last_o,
    output logic          tx_done_o,
    output logic          busy_o
);
    localparam int SEG_W = LEN_W + 2;
    localparam int CNT_W = $clog2(MAX_PKTS + 1);

    txr_state_e state_q, state_d;

    logic [AW-1:0]    cur_q, walk_q, buf_q, walk_nx;
    logic [TOT_W-1:0] tot_q, keep_q, pos_q;
    logic [SEG_W-1:0] seg_left_q, seg_len;
    logic [31:0]      word_q;
    logic [1:0]       lane_q;
    logic             fs_q, ls_q;
    logic [CNT_W-1:0] pkt_cnt_q;

    logic             own_w, fs_w, ls_w, rel_go, emit_valid;
    logic [1:0]       pad_w, trim2;
    logic [TOT_W-1:0] tot_sum, trim_w, keep_w;

    assign own_w = mem_rdata_i[OWN_BIT];
    assign fs_w  = mem_rdata_i[FS_BIT];
    assign ls_w  = mem_rdata_i[LS_BIT];
    assign pad_w = mem_rdata_i[PAD_LO+1:PAD_LO];

    txr_seglen #(.LEN_W(LEN_W)) u_seglen (
        .mode_i   (mode_i),
        .len_i    (mem_rdata_i[LEN_W-1:0]),
        .sub_en_i (mem_rdata_i[SUB_EN_BIT]),
        .sub_i    (mem_rdata_i[SUB_LO+1:SUB_LO]),
        .seg_len_o(seg_len)
    );

    txr_ring_step #(.AW(AW), .STEP(DESC_BYTES)) u_step (
        .mode_i (mode_i),
        .ptr_i  (walk_q),
        .start_i(ring_start_i),
        .end_i  (ring_end_i),
        .next_o (walk_nx)
    );

    // Packet length bookkeeping for the ownership walk
    always_comb begin
        tot_sum = tot_q + TOT_W'(seg_len);
        trim2   = 2'd0 - pad_w;
        trim_w  = TOT_W'(trim2);
        keep_w  = (tot_sum > trim_w) ? (tot_sum - trim_w) : '0;
        rel_go  = fs_q || mem_ack_i;
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (scan_req_i) state_d = ST_START;
            ST_START:   state_d = line_ready_i ? ST_SCAN : ST_IDLE;
            ST_SCAN: begin
                if (mem_ack_i) begin
                    if (!own_w)     state_d = ST_IDLE;
                    else if (ls_w)  state_d = ST_DESC0;
                end
            end
            ST_DESC0:   if (mem_ack_i) state_d = ST_DESC1;
            ST_DESC1: begin
                if (mem_ack_i) state_d = (seg_left_q == '0) ? ST_RELEASE : ST_FETCH;
            end
            ST_FETCH:   if (mem_ack_i) state_d = ST_EMIT;
            ST_EMIT: begin
                if (seg_left_q == SEG_W'(1)) state_d = ST_RELEASE;
                else if (lane_q == 2'd3)     state_d = ST_FETCH;
            end
            ST_RELEASE: if (rel_go) state_d = ls_q ? ST_HEADCLR : ST_DESC0;
            ST_HEADCLR: begin
                if (mem_ack_i) begin
                    state_d = (pkt_cnt_q == CNT_W'(MAX_PKTS - 1)) ? ST_IDLE : ST_START;
                end
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = walk_q;
        mem_wdata_o = '0;
        emit_valid  = 1'b0;
        tx_done_o   = 1'b0;
        unique case (state_q)
            ST_SCAN, ST_DESC0: mem_req_o = 1'b1;
            ST_DESC1: begin
                mem_req_o  = 1'b1;
                mem_addr_o = walk_q + AW'(4);
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = buf_q;
            end
            ST_EMIT:    emit_valid = (pos_q < keep_q);
            ST_RELEASE: begin
                mem_req_o = !fs_q;
                mem_we_o  = !fs_q;
            end
            ST_HEADCLR: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = cur_q;
                tx_done_o  = mem_ack_i;
            end
            default: ;
        endcase
        byte_valid_o = emit_valid;
        byte_data_o  = word_q[lane_q*8 +: 8];
        byte_last_o  = emit_valid && (pos_q == keep_q - TOT_W'(1));
        busy_o       = (state_q != ST_IDLE);
    end

    // Datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q      <= '0;
            walk_q     <= '0;
            buf_q      <= '0;
            tot_q      <= '0;
            keep_q     <= '0;
            pos_q      <= '0;
            seg_left_q <= '0;
            word_q     <= '0;
            lane_q     <= '0;
            fs_q       <= 1'b0;
            ls_q       <= 1'b0;
            pkt_cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ring_init_i) cur_q <= ring_start_i;
                    if (scan_req_i)  pkt_cnt_q <= '0;
                end
                ST_START: begin
                    walk_q <= cur_q;
                    tot_q  <= '0;
                end
                ST_SCAN: begin
                    if (mem_ack_i && own_w) begin
                        tot_q <= tot_sum;
                        if (ls_w) begin
                            keep_q <= keep_w;
                            pos_q  <= '0;
                            walk_q <= cur_q;
                        end else begin
                            walk_q <= walk_nx;
                        end
                    end
                end
                ST_DESC0: begin
                    if (mem_ack_i) begin
                        fs_q       <= fs_w;
                        ls_q       <= ls_w;
                        seg_left_q <= seg_len;
                    end
                end
                ST_DESC1:   if (mem_ack_i) buf_q <= mem_rdata_i;
                ST_FETCH: begin
                    if (mem_ack_i) begin
                        word_q <= mem_rdata_i;
                        lane_q <= '0;
                    end
                end
                ST_EMIT: begin
                    pos_q      <= pos_q + TOT_W'(1);
                    seg_left_q <= seg_left_q - SEG_W'(1);
                    lane_q     <= lane_q + 2'd1;
                    if (lane_q == 2'd3 && seg_left_q != SEG_W'(1)) buf_q <= buf_q + AW'(4);
                end
                ST_RELEASE: if (rel_go) walk_q <= walk_nx;
                ST_HEADCLR: begin
                    if (mem_ack_i) begin
                        cur_q     <= walk_q;
                        pkt_cnt_q <= pkt_cnt_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Observation state for the assertions
    logic             tail_q;
    logic [CNT_W-1:0] pass_done_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tail_q      <= 1'b0;
            pass_done_q <= '0;
        end else begin
            if (tx_done_o)        tail_q <= 1'b0;
            else if (byte_last_o) tail_q <= 1'b1;
            if (state_q == ST_IDLE && scan_req_i) pass_done_q <= '0;
            else if (tx_done_o)                   pass_done_q <= pass_done_q + CNT_W'(1);
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_done_o |=> !tx_done_o); // R7
    AST_NO_TAIL_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tail_q |-> !byte_valid_o); // R4
    AST_PASS_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_done_o |-> (pass_done_q < CNT_W'(MAX_PKTS))); // R9
    AST_MODE0_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_done_o && !mode_i) |=> (cur_q != ring_end_i)); // R8

endmodule

// File: tb/txr_ring_reader_bench.sv
module txr_ring_reader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] rstart = '0, rend = '0;
    logic        rinit = 1'b0, sreq = 1'b0, lready = 1'b1, slow = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        byte_valid, byte_last, tx_done, busy;
    logic [7:0]  byte_data;

    always #4 clk = ~clk;

    txr_ring_reader u_txr_ring_reader (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
        .ring_start_i(rstart), .ring_end_i(rend), .ring_init_i(rinit),
        .scan_req_i(sreq), .line_ready_i(lready),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .byte_valid_o(byte_valid), .byte_data_o(byte_data), .byte_last_o(byte_last),
        .tx_done_o(tx_done), .busy_o(busy)
    );

    // Host memory model: 128 words, optional alternate-cycle wait states
    logic [31:0] mem [128];
    logic        tick = 1'b0;
    assign mem_ack   = mem_req && (!slow || tick);
    assign mem_rdata = mem[mem_addr[8:2]];
    always @(posedge clk) begin
        tick <= ~tick;
        if (mem_req && mem_we && mem_ack) mem[mem_addr[8:2]] <= mem_wdata;
    end

    int n_checks = 0, n_err = 0;
    int cap_n, last_cnt, last_idx, done_n, wr_n;
    logic [7:0]  cap_b [64];
    logic [31:0] wr_a [8];

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                if (cap_n < 64) cap_b[cap_n] = byte_data;
                if (byte_last) begin last_cnt++; last_idx = cap_n; end
                cap_n++;
            end
            if (tx_done) done_n++;
            if (mem_req && mem_we && mem_ack) begin
                if (wr_n < 8) wr_a[wr_n] = mem_addr;
                wr_n++;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
        mem[a[8:2]]        <= w0;
        mem[a[8:2] + 7'd1] <= w1;
    endtask

    task automatic clear_ring();
        for (int i = 0; i < 64; i++) mem[i] <= '0;
    endtask

    task automatic init_ring(input logic m, input logic [31:0] s, input logic [31:0] e);
        @(posedge clk); #1;
        mode = m; rstart = s; rend = e; rinit = 1'b1;
        @(posedge clk); #1;
        rinit = 1'b0;
    endtask

    task automatic run_pass();
        cap_n = 0; last_cnt = 0; last_idx = -1; done_n = 0; wr_n = 0;
        @(posedge clk); #1 sreq = 1'b1;
        @(posedge clk); #1 sreq = 0;
        do @(negedge clk); while (busy);
        repeat (2) @(negedge clk);
    endtask

    // {mode, descriptor word 0, kept bytes}; buffer always at 0x100
    localparam logic [40:0] VEC [7] = '{
        {1'b0, 32'hE040_0005, 8'd2},
        {1'b0, 32'hE000_0008, 8'd8},
        {1'b1, 32'hE080_0003, 8'd10},
        {1'b1, 32'hE3D0_0003, 8'd8},
        {1'b0, 32'hE000_0000, 8'd0},
        {1'b0, 32'hE040_0002, 8'd0},
        {1'b1, 32'hE0C0_0001, 8'd3}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        for (int i = 64; i < 128; i++) begin
            logic [7:0] b;
            b = 8'(i * 4);
            mem[i] = {b + 8'd3, b + 8'd2, b + 8'd1, b};
        end
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R11 reset req", {31'd0, mem_req}, 0);
        check("R11 reset stream", {31'd0, byte_valid}, 0);
        check("R11 reset busy", {31'd0, busy}, 0);
        check("R11 reset done", {31'd0, tx_done}, 0);
        #1 rst_n = 1'b1;

        // Vector table
        for (int v = 0; v < 7; v++) begin
            logic        vm;
            logic [31:0] vw0;
            logic [7:0]  vk;
            {vm, vw0, vk} = VEC[v];
            clear_ring();
            put(32'h0, vw0, 32'h100);
            init_ring(vm, 32'h0, 32'h40);
            run_pass();
            check(vm ? "R3 kept length" : "R2 kept length", cap_n, 32'(vk));
            for (int k = 0; k < int'(vk); k++) check("R5 byte value", 32'(cap_b[k]), 32'(k));
            check("R4 last count", last_cnt, (vk != 0) ? 1 : 0);
            if (vk != 0) check("R4 last position", last_idx, 32'(vk) - 1);
            check("R7 done count", done_n, 1);
            check("R1 R7 head cleared", mem[0], 0);
        end

        // Chain with zero-length middle segment under wait states
        slow = 1'b1;
        clear_ring();
        put(32'h00, 32'hC000_0005, 32'h100);
        put(32'h08, 32'h8000_0000, 32'h140);
        put(32'h10, 32'hA000_0006, 32'h180);
        init_ring(1'b0, 32'h0, 32'h40);
        run_pass();
        slow = 1'b0;
        check("R10 R5 chain length", cap_n, 11);
        for (int k = 0; k < 11; k++)
            check("R5 chain byte", 32'(cap_b[k]), (k < 5) ? 32'(k) : 32'(8'h80 + k - 5));
        check("R4 chain last", last_idx, 10);
        check("R7 write count", wr_n, 3);
        check("R7 first write", wr_a[0], 32'h08);
        check("R7 second write", wr_a[1], 32'h10);
        check("R7 head write last", wr_a[2], 32'h00);
        check("R7 middle cleared", mem[2], 0);
        check("R7 done", done_n, 1);

        // Abort on non-owned descriptor
        clear_ring();
        put(32'h00, 32'hC000_0004, 32'h100);
        init_ring(1'b0, 32'h0, 32'h40);
        run_pass();
        check("R6 no bytes", cap_n, 0);
        check("R6 no done", done_n, 0);
        check("R6 no writes", wr_n, 0);
        check("R6 head untouched", mem[0], 32'hC000_0004);
        check("R9 pass ended", {31'd0, busy}, 0);
        put(32'h08, 32'hA000_0004, 32'h140);
        run_pass();
        check("R6 pointer kept", cap_n, 8);
        check("R5 second segment", 32'(cap_b[4]), 32'h40);

        // Line not ready
        clear_ring();
        put(32'h00, 32'hE000_0004, 32'h100);
        init_ring(1'b0, 32'h0, 32'h40);
        lready = 1'b0;
        run_pass();
        check("R9 not ready bytes", cap_n, 0);
        check("R9 not ready desc", mem[0], 32'hE000_0004);
        lready = 1'b1;
        run_pass();
        check("R9 ready done", done_n, 1);

        // Wrap rules
        clear_ring();
        put(32'h00, 32'hE000_0004, 32'h100);
        put(32'h08, 32'hE000_0004, 32'h100);
        init_ring(1'b0, 32'h0, 32'h08);
        run_pass();
        check("R8 mode0 done", done_n, 1);
        check("R8 mode0 second slot unused", mem[2], 32'hE000_0004);
        clear_ring();
        put(32'h00, 32'hE000_0004, 32'h100);
        put(32'h08, 32'hE000_0004, 32'h100);
        init_ring(1'b1, 32'h0, 32'h08);
        run_pass();
        check("R8 mode1 done", done_n, 2);
        check("R8 mode1 second slot used", mem[2], 0);
        put(32'h00, 32'hE000_0004, 32'h100);
        run_pass();
        check("R8 mode1 wrapped", done_n, 1);

        // Pass limit
        clear_ring();
        for (int i = 0; i < 20; i++) put(32'(i * 8), 32'hE000_0004, 32'h100);
        init_ring(1'b0, 32'h0, 32'hF8);
        run_pass();
        check("R9 limit done", done_n, 16);
        check("R9 next left owned", mem[32], 32'hE000_0004);
        run_pass();
        check("R9 remainder done", done_n, 4);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule